// File: doc/BRIEF.md
# SPI Data-Line Timing Adjuster

This block sits between an SPI master engine and its pads. It retimes the data lines in whole core-clock cycles. The outgoing data line can be held back by 0 to 3 cycles. The incoming data line can also be held back by 0 to 3 cycles. The block produces the receive capture strobe itself, from a phase counter that follows the bit period while the engine is busy. That strobe can fire two cycles early, one cycle early, on the nominal edge, or one cycle late.

In manual mode the three settings come straight from the configuration inputs. In auto mode they are chosen from a 2-bit rate-band code and from the current bit-rate division.

All settings, the division included, are copied into an active set only on clock edges where the engine is idle. A configuration change made during a transfer therefore takes effect at the next idle edge.

Top module: `spi_tadj`

## Requirements
- R1: With an active output-delay code n (0 to 3), `mo_out` equals the value `mo_in` had n cycles earlier; code 0 is a same-cycle pass-through.
- R2: With an active input-delay code n (0 to 3), `mi_dly` equals the value `mi_in` had n cycles earlier; code 0 is a same-cycle pass-through.
- R3: Let D be the active division and count the edges at which `busy` is sampled high, starting from 1 after each idle edge. Capture code 2 (nominal) makes `cap_stb` high for the one cycle after edges D, 2D, and so on. Code 1 moves this to after edges nD-1, code 0 to after nD-2, and code 3 to after nD+1.
- R4: With `auto_en` high, the output delay is 0. Band code 3 gives capture code 3, band 2 gives code 2, band 1 gives code 1, and in all three the input delay is 0.
- R5: With `auto_en` high and band code 0, the capture code is 0. The input delay is 3 for a division of 16 or more, 2 for 8 to 15, 1 for 6 or 7, and 0 below 6.
- R6: Configuration, mode, band and division are adopted only at edges where `busy` is low. Changes made while `busy` is high have no effect until the next such edge.
- R7: At the edge that ends a cycle with `cap_stb` high, `rx_bit` takes the value of `mi_dly` in that cycle. At every other edge it holds its value.
- R8: A division input below 4 is treated as 4.
- R9: Reset clears all delay stages, `cap_stb` and `rx_bit`. It sets the active settings to zero output delay, zero input delay, nominal capture and a division of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | Engine is shifting a transfer |
| auto_en | input | 1 | Choose settings from band and division |
| mo_dly_cfg | input | 2 | Manual output-delay code |
| mi_dly_cfg | input | 2 | Manual input-delay code |
| cap_cfg | input | 2 | Manual capture code (0: 2 early, 1: 1 early, 2: nominal, 3: 1 late) |
| rate_band | input | 2 | Rate band, 3 is fastest |
| div_ratio | input | DIV_W | Core cycles per SPI bit |
| mo_in | input | 1 | Outgoing data from the engine |
| mi_in | input | 1 | Incoming data from the pad |
| mo_out | output | 1 | Delayed outgoing data |
| mi_dly | output | 1 | Delayed incoming data |
| cap_stb | output | 1 | Receive capture strobe |
| rx_bit | output | 1 | Last captured input bit |

## Verification
Random data is driven on both data lines in every cycle. A zero delay and every other delay code therefore give different outputs, and the delay codes cannot be told apart only by chance. Capture codes are swept against divisions 4, 6 and 8, so that an off-by-one in the strobe position shows up as a strobe in the wrong cycle and a wrong captured bit. Auto mode is driven across every band and across divisions on both sides of the 6, 8 and 16 thresholds. Further runs change the configuration in the middle of a transfer and give divisions below the minimum; these separate correct idle-only adoption and clamping from immediate adoption.

// File: rtl/spi_tadj_pkg.sv
package spi_tadj_pkg;

    localparam int unsigned DLY_W   = 2;
    localparam int unsigned MAX_DLY = (1 << DLY_W) - 1;

    typedef enum logic [1:0] {
        CAP_AHEAD2  = 2'd0,
        CAP_AHEAD1  = 2'd1,
        CAP_NOMINAL = 2'd2,
        CAP_LATE1   = 2'd3
    } cap_pos_e;

    typedef struct packed {
        logic [DLY_W-1:0] out_dly;
        logic [DLY_W-1:0] in_dly;
        cap_pos_e         cap;
    } tdly_set_t;

    localparam tdly_set_t SET_RESET = '{out_dly: '0, in_dly: '0, cap: CAP_NOMINAL};

endpackage

// File: rtl/tadj_delay_line.sv
module tadj_delay_line #(
    parameter int unsigned DEPTH = spi_tadj_pkg::MAX_DLY,
    parameter int unsigned SEL_W = spi_tadj_pkg::DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);
    logic [DEPTH-1:0] stage_d, stage_q;
    logic [DEPTH:0]   taps;

    assign taps[0] = din;
    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
        assign taps[i+1] = stage_q[i];
    end

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
        if (int'(sel) <= DEPTH) begin
            dout = taps[sel];
        end else begin
            dout = taps[DEPTH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end
endmodule

// File: rtl/tadj_auto_sel.sv
module tadj_auto_sel
    import spi_tadj_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             auto_en,
    input  tdly_set_t        manual,
    input  logic [1:0]       band,
    input  logic [DIV_W-1:0] div,
    output tdly_set_t        sel
);
    localparam logic [DIV_W-1:0] THR_3 = DIV_W'(16);
    localparam logic [DIV_W-1:0] THR_2 = DIV_W'(8);
    localparam logic [DIV_W-1:0] THR_1 = DIV_W'(6);

    always_comb begin
        sel = manual;
        if (auto_en) begin
            sel.out_dly = '0;
            sel.in_dly  = '0;
            sel.cap     = CAP_AHEAD2;
            unique case (band)
                2'd3: sel.cap = CAP_LATE1;
                2'd2: sel.cap = CAP_NOMINAL;
                2'd1: sel.cap = CAP_AHEAD1;
                default: begin
                    if (div >= THR_3) begin
                        sel.in_dly = DLY_W'(3);
                    end else if (div >= THR_2) begin
                        sel.in_dly = DLY_W'(2);
                    end else if (div >= THR_1) begin
                        sel.in_dly = DLY_W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tadj_strobe_gen.sv
module tadj_strobe_gen
    import spi_tadj_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic [DIV_W-1:0] div,
    input  cap_pos_e         cap,
    output logic             stb
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             hit;
        logic             late;
    } sg_state_t;

    sg_state_t st_d, st_q;
    logic [DIV_W-1:0] last_ph;
    logic [DIV_W-1:0] ahead;
    logic [DIV_W-1:0] target;

    always_comb begin
        last_ph = div - DIV_W'(1);
        unique case (cap)
            CAP_AHEAD2: ahead = DIV_W'(2);
            CAP_AHEAD1: ahead = DIV_W'(1);
            default:    ahead = '0;
        endcase
        target = last_ph - ahead;

        st_d      = st_q;
        st_d.late = st_q.hit;
        st_d.hit  = busy && (st_q.cnt == target);
        if (!busy || st_q.cnt == last_ph) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end

        stb = (cap == CAP_LATE1) ? st_q.late : st_q.hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_tadj.sv
module spi_tadj
    import spi_tadj_pkg::*;
#(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             auto_en,
    input  logic [1:0]       mo_dly_cfg,
    input  logic [1:0]       mi_dly_cfg,
    input  logic [1:0]       cap_cfg,
    input  logic [1:0]       rate_band,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic             mo_in,
    input  logic             mi_in,
    output logic             mo_out,
    output logic             mi_dly,
    output logic             cap_stb,
    output logic             rx_bit
);
    localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

    typedef struct packed {
        tdly_set_t        act;
        logic [DIV_W-1:0] div;
        logic             rx;
    } top_state_t;

    top_state_t st_d, st_q;
    tdly_set_t  manual_set, picked;
    logic [DIV_W-1:0] div_cl;

    always_comb begin
        div_cl = (div_ratio < DIV_FLOOR) ? DIV_FLOOR : div_ratio;
        manual_set.out_dly = mo_dly_cfg;
        manual_set.in_dly  = mi_dly_cfg;
        manual_set.cap     = cap_pos_e'(cap_cfg);
    end

    tadj_auto_sel #(.DIV_W(DIV_W)) u_sel (
        .auto_en (auto_en),
        .manual  (manual_set),
        .band    (rate_band),
        .div     (div_cl),
        .sel     (picked)
    );

    tadj_delay_line u_mo_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mo_in),
        .sel   (st_q.act.out_dly),
        .dout  (mo_out)
    );

    tadj_delay_line u_mi_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mi_in),
        .sel   (st_q.act.in_dly),
        .dout  (mi_dly)
    );

    tadj_strobe_gen #(.DIV_W(DIV_W)) u_stb (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .div   (st_q.div),
        .cap   (st_q.act.cap),
        .stb   (cap_stb)
    );

    always_comb begin
        st_d = st_q;
        if (!busy) begin
            st_d.act = picked;
            st_d.div = div_cl;
        end
        if (cap_stb) begin
            st_d.rx = mi_dly;
        end
    end

    assign rx_bit = st_q.rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act <= SET_RESET;
            st_q.div <= DIV_FLOOR;
            st_q.rx  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_tadj_chk.sv
module spi_tadj_chk #(
    parameter int unsigned ACT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mo_in,
    input logic             mo_out,
    input logic             mi_in,
    input logic             mi_dly,
    input logic             cap_stb,
    input logic             rx_bit,
    input logic [1:0]       out_dly,
    input logic [1:0]       in_dly,
    input logic [ACT_W-1:0] act_bits
);
    AST_STB_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> ($past(busy) || $past(busy, 2))); // R3

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_stb) |-> $stable(rx_bit)); // R7

    AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(act_bits)); // R6

    AST_MO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_dly == 2'd1) |-> (mo_out == $past(mo_in))); // R1

    AST_MI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && in_dly == 2'd1) |-> (mi_dly == $past(mi_in))); // R2
endmodule

bind spi_tadj spi_tadj_chk #(.ACT_W(6 + DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mo_in    (mo_in),
    .mo_out   (mo_out),
    .mi_in    (mi_in),
    .mi_dly   (mi_dly),
    .cap_stb  (cap_stb),
    .rx_bit   (rx_bit),
    .out_dly  (st_q.act.out_dly),
    .in_dly   (st_q.act.in_dly),
    .act_bits ({st_q.act, st_q.div})
);

// File: tb/spi_tadj_test.sv
module spi_tadj_test;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b0, auto_en = 1'b0;
    logic [1:0] mo_dly_cfg = '0, mi_dly_cfg = '0, cap_cfg = 2'd2, rate_band = '0;
    logic [DIV_W-1:0] div_ratio = 8'd4;
    logic mo_in = 1'b0, mi_in = 1'b0;
    logic mo_out, mi_dly, cap_stb, rx_bit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R9";

    // reference model state
    int m_mo = 0, m_mi = 0, m_cap = 2, m_div = 4, m_cnt = 0;
    bit m_stb = 0, m_late = 0, m_rx = 0;
    bit mo_h[$];
    bit mi_h[$];

    always #10 clk = ~clk;

    spi_tadj #(.DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .auto_en(auto_en),
        .mo_dly_cfg(mo_dly_cfg), .mi_dly_cfg(mi_dly_cfg), .cap_cfg(cap_cfg),
        .rate_band(rate_band), .div_ratio(div_ratio), .mo_in(mo_in), .mi_in(mi_in),
        .mo_out(mo_out), .mi_dly(mi_dly), .cap_stb(cap_stb), .rx_bit(rx_bit)
    );

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cyc);
        end
    endtask

    // settings chosen from the requirements (R4, R5, R8)
    task automatic pick(output int mo, output int mi, output int cp, output int dv);
        dv = (int'(div_ratio) < 4) ? 4 : int'(div_ratio);
        if (!auto_en) begin
            mo = mo_dly_cfg; mi = mi_dly_cfg; cp = cap_cfg;
        end else begin
            mo = 0; mi = 0;
            if (rate_band == 3) cp = 3;
            else if (rate_band == 2) cp = 2;
            else if (rate_band == 1) cp = 1;
            else begin
                cp = 0;
                if (dv >= 16) mi = 3;
                else if (dv >= 8) mi = 2;
                else if (dv >= 6) mi = 1;
            end
        end
    endtask

    // one cycle: inputs already applied at the falling edge
    task automatic step();
        bit e_mo, e_mi, e_stb;
        int ahead, n_mo, n_mi, n_cp, n_dv;
        #1;
        e_mo  = (m_mo == 0) ? mo_in : mo_h[m_mo-1];
        e_mi  = (m_mi == 0) ? mi_in : mi_h[m_mi-1];
        e_stb = (m_cap == 3) ? m_late : m_stb;
        chk("mo_out (R1)", mo_out, e_mo);
        chk("mi_dly (R2)", mi_dly, e_mi);
        chk("cap_stb (R3)", cap_stb, e_stb);
        chk("rx_bit (R7)", rx_bit, m_rx);
        // advance model to the next rising edge
        if (e_stb) m_rx = e_mi;
        ahead = (m_cap == 0) ? 2 : (m_cap == 1) ? 1 : 0;
        m_late = m_stb;
        m_stb = busy && (m_cnt == m_div - 1 - ahead);
        m_cnt = (!busy || m_cnt == m_div - 1) ? 0 : m_cnt + 1;
        mo_h.push_front(mo_in); void'(mo_h.pop_back());
        mi_h.push_front(mi_in); void'(mi_h.pop_back());
        if (!busy) begin
            pick(n_mo, n_mi, n_cp, n_dv);
            m_mo = n_mo; m_mi = n_mi; m_cap = n_cp; m_div = n_dv;
        end
        @(negedge clk);
        mo_in = 1'($urandom);
        mi_in = 1'($urandom);
    endtask

    task automatic run(int idle, int len);
        busy = 1'b0;
        for (int i = 0; i < idle; i++) step();
        busy = 1'b1;
        for (int i = 0; i < len; i++) step();
        busy = 1'b0;
    endtask

    task automatic set_man(int mo, int mi, int cp, int dv);
        auto_en = 1'b0;
        mo_dly_cfg = 2'(mo); mi_dly_cfg = 2'(mi); cap_cfg = 2'(cp); div_ratio = 8'(dv);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int dl[3];
        int dv5[8];
        dl = '{4, 6, 8};
        dv5 = '{4, 5, 6, 7, 8, 15, 16, 20};
        for (int i = 0; i < 3; i++) begin mo_h.push_back(0); mi_h.push_back(0); end

        // R9: reset state
        repeat (3) @(negedge clk);
        cur_req = "R9";
        #1;
        chk("mo_out in reset (R9)", mo_out, 0);
        chk("cap_stb in reset (R9)", cap_stb, 0);
        chk("rx_bit in reset (R9)", rx_bit, 0);
        rst_n = 1'b1;
        mo_in = 1'b1; mi_in = 1'b1;
        #1;
        chk("mo_out pass-through after reset (R9)", mo_out, 1);
        chk("mi_dly pass-through after reset (R9)", mi_dly, 1);
        @(negedge clk);
        busy = 1'b1;
        for (int i = 0; i < 10; i++) step();

        cur_req = "R1 R2";
        for (int c = 0; c < 4; c++) begin
            set_man(c, 3 - c, 2, 4);
            run(2, 12);
        end

        cur_req = "R3 R7";
        for (int cp = 0; cp < 4; cp++) begin
            for (int k = 0; k < 3; k++) begin
                set_man(1, 2, cp, dl[k]);
                run(3, 3 * dl[k] + 2);
            end
        end

        cur_req = "R4";
        for (int b = 1; b < 4; b++) begin
            set_man(3, 3, 0, 6);
            auto_en = 1'b1; rate_band = 2'(b);
            run(2, 20);
        end

        cur_req = "R5";
        for (int k = 0; k < 8; k++) begin
            set_man(2, 0, 3, dv5[k]);
            auto_en = 1'b1; rate_band = 2'd0;
            run(2, 2 * dv5[k] + 1);
        end

        cur_req = "R6";
        set_man(0, 0, 2, 4);
        run(2, 5);
        busy = 1'b1;
        set_man(3, 3, 0, 8);
        for (int i = 0; i < 12; i++) step();
        auto_en = 1'b1; rate_band = 2'd3;
        for (int i = 0; i < 6; i++) step();
        run(2, 16);

        cur_req = "R8";
        for (int d = 0; d < 4; d++) begin
            set_man(1, 1, 2, d);
            run(2, 10);
        end

        cur_req = "R1 R2 R3 R4 R5 R6 R7 random";
        for (int n = 0; n < 40; n++) begin
            set_man($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                    $urandom_range(0, 20));
            auto_en = 1'($urandom); rate_band = 2'($urandom);
            run($urandom_range(0, 3), $urandom_range(1, 30));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule